// File: doc/BRIEF.md
# Windowed Phase-Lock Detector

This block decides whether a phase-locked loop is in lock by watching the phase-error pulse that its phase-frequency detector produces. A fast sample clock counts how many of its cycles the error pulse is high during each comparison cycle. A strobe marks the end of each comparison cycle. At that strobe the accumulated width is compared against a programmable time window. A comparison whose pulse is narrower than the window counts as coincident.

The two outputs behave differently. The lock flag goes high only after a programmable run of consecutive coincident comparisons. The unlock flag follows every single comparison at once. It rises on any comparison outside the window and falls on the next comparison that is inside it. The window and the run length each come from a fixed table indexed by a 2-bit code. A 4-bit status word collects both flags with the enable state and the progress state, so that a register file can read it.

Top module: `pll_lock_judge`

## Requirements
- R1: A comparison is coincident when the number of sample-clock cycles with `phase_err` high counts below the window length in sample cycles. The count runs from the cycle after the previous strobe up to and including the strobe cycle. The window length in sample cycles is the window time divided by `SAMPLE_PS`, and it is never less than 1.
- R2: Window code `win_sel` maps 0 to 3 ns, 1 to 10 ns, 2 to 30 ns and 3 to 90 ns. With the default `SAMPLE_PS` of 1000 these are 3, 10, 30 and 90 sample cycles.
- R3: Count code `cnt_sel` maps 0 to 32, 1 to 128, 2 to 512 and 3 to 2048 consecutive coincident comparisons.
- R4: `lock_o` rises at the clock edge of the strobe that completes the selected number of consecutive coincident comparisons, and never earlier.
- R5: At an out-of-window strobe, `unlock_o` is set, `lock_o` is cleared and the consecutive count returns to zero, all at the same edge.
- R6: `unlock_o` is cleared at the edge of the first coincident strobe that follows.
- R7: The consecutive count saturates at its target, so `lock_o` stays high while coincident comparisons continue.
- R8: While `enable` is low, both flags and the consecutive count are zero from the next edge onward. After re-enabling, the full count must be reached again.
- R9: A change of `win_sel` or `cnt_sel` restarts the consecutive count and clears `lock_o` at the next edge, and it leaves `unlock_o` unchanged. A strobe in that same cycle is ignored.
- R10: `status_o` bit 0 is the lock flag, bit 1 the unlock flag, bit 2 mirrors `enable`, and bit 3 is set while the consecutive count is nonzero.
- R11: During and right after synchronous reset, `lock_o`, `unlock_o` and the count are zero.
- R12: `lock_o` and `unlock_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sample clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Runs the detector when high |
| win_sel | input | 2 | Window code |
| cnt_sel | input | 2 | Consecutive-count code |
| phase_err | input | 1 | Phase-error pulse from the detector, sampled each clock |
| cmp_strobe | input | 1 | Marks the last sample of a comparison cycle |
| lock_o | output | 1 | Lock flag |
| unlock_o | output | 1 | Unlock flag |
| status_o | output | 4 | Status word (see R10) |

## Verification
The bench aims at the exact edge on which lock appears. It checks at N-1 and N consecutive good comparisons for two count codes. A design with an off-by-one run counter would raise lock one comparison early or one late. It probes the window boundary, width equal to the limit minus one against width equal to the limit, for three window codes. A comparator with the wrong polarity or the wrong table would flip unlock there. It also checks that unlock drops on the first good comparison rather than waiting for lock. It checks that a configuration change or a disable clears lock but does not touch unlock wrongly. Finally it checks that lock holds after the count saturates, where a counter that wraps would drop lock.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;

    localparam int unsigned MEAS_W = 8;
    localparam int unsigned RUN_W  = 12;

    typedef logic [1:0] sel_t;

    typedef struct packed {
        logic run_active;
        logic enabled;
        logic unlock;
        logic lock;
    } status_t;

    typedef struct packed {
        logic valid;
        logic good;
    } verdict_t;

    function automatic int unsigned window_ps(sel_t code);
        case (code)
            2'd0:    return 3000;
            2'd1:    return 10000;
            2'd2:    return 30000;
            default: return 90000;
        endcase
    endfunction

    function automatic int unsigned window_cycles(sel_t code, int unsigned sample_ps);
        int unsigned n;
        n = window_ps(code) / sample_ps;
        if (n == 0) n = 1;
        return n;
    endfunction

    function automatic logic [RUN_W-1:0] target_count(sel_t code);
        logic [RUN_W-1:0] base;
        base = RUN_W'(32);
        return base << (2 * code);
    endfunction

endpackage

// File: rtl/plj_width_meter.sv
module plj_width_meter
    import pll_lock_pkg::*;
#(
    parameter int unsigned SAMPLE_PS = 1000,
    parameter int unsigned MW        = MEAS_W
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     clear,
    input  logic     phase_err,
    input  logic     strobe,
    input  sel_t     win_sel,
    output verdict_t verdict
);
    localparam logic [MW-1:0] SAT = {MW{1'b1}};

    logic [MW-1:0] acc;
    logic [MW-1:0] total;
    logic [MW:0]   limit [4];

    for (genvar g = 0; g < 4; g++) begin : g_lim
        localparam int unsigned CYC = window_cycles(sel_t'(g), SAMPLE_PS);
        assign limit[g] = (MW + 1)'(CYC);
    end

    always_comb begin
        if (phase_err && acc != SAT) total = acc + MW'(1);
        else                          total = acc;
        verdict.valid = strobe;
        verdict.good  = ({1'b0, total} < limit[win_sel]);
    end

    always_ff @(posedge clk) begin
        if (rst || clear || strobe) acc <= '0;
        else                        acc <= total;
    end

endmodule

// File: rtl/plj_cfg_watch.sv
module plj_cfg_watch
    import pll_lock_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  sel_t win_sel,
    input  sel_t cnt_sel,
    output logic changed
);
    sel_t win_q;
    sel_t cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '0;
            cnt_q <= '0;
        end else begin
            win_q <= win_sel;
            cnt_q <= cnt_sel;
        end
    end

    assign changed = (win_q != win_sel) || (cnt_q != cnt_sel);

endmodule

// File: rtl/plj_run_tracker.sv
module plj_run_tracker
    import pll_lock_pkg::*;
#(
    parameter int unsigned RW = RUN_W
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     enable,
    input  logic     restart,
    input  verdict_t verdict,
    input  sel_t     cnt_sel,
    output logic     lock,
    output logic     unlock,
    output logic     run_active
);
    logic [RW-1:0] run;
    logic [RW-1:0] target;
    logic [RW-1:0] run_nxt;

    always_comb begin
        target  = target_count(cnt_sel);
        run_nxt = (run >= target) ? target : run + RW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            run    <= '0;
            lock   <= 1'b0;
            unlock <= 1'b0;
        end else if (restart) begin
            run  <= '0;
            lock <= 1'b0;
        end else if (verdict.valid) begin
            if (verdict.good) begin
                run    <= run_nxt;
                lock   <= (run_nxt == target);
                unlock <= 1'b0;
            end else begin
                run    <= '0;
                lock   <= 1'b0;
                unlock <= 1'b1;
            end
        end
    end

    assign run_active = (run != '0);

endmodule

// File: rtl/pll_lock_judge.sv
module pll_lock_judge
    import pll_lock_pkg::*;
#(
    parameter int unsigned SAMPLE_PS = 1000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic [1:0] win_sel,
    input  logic [1:0] cnt_sel,
    input  logic       phase_err,
    input  logic       cmp_strobe,
    output logic       lock_o,
    output logic       unlock_o,
    output logic [3:0] status_o
);
    verdict_t verdict;
    logic     cfg_changed;
    logic     run_active;
    status_t  status;

    plj_cfg_watch u_cfg (
        .clk     (clk),
        .rst     (rst),
        .win_sel (win_sel),
        .cnt_sel (cnt_sel),
        .changed (cfg_changed)
    );

    plj_width_meter #(.SAMPLE_PS(SAMPLE_PS)) u_meter (
        .clk       (clk),
        .rst       (rst),
        .clear     (!enable || cfg_changed),
        .phase_err (phase_err),
        .strobe    (cmp_strobe),
        .win_sel   (win_sel),
        .verdict   (verdict)
    );

    plj_run_tracker u_run (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .restart    (cfg_changed),
        .verdict    (verdict),
        .cnt_sel    (cnt_sel),
        .lock       (lock_o),
        .unlock     (unlock_o),
        .run_active (run_active)
    );

    always_comb begin
        status.lock       = lock_o;
        status.unlock     = unlock_o;
        status.enabled    = enable;
        status.run_active = run_active;
    end

    assign status_o = status;

endmodule

// File: rtl/plj_checker.sv
module plj_checker (
    input logic       clk,
    input logic       rst,
    input logic       enable,
    input logic [1:0] win_sel,
    input logic [1:0] cnt_sel,
    input logic       cmp_strobe,
    input logic       lock_o,
    input logic       unlock_o,
    input logic [3:0] status_o
);
    // R12
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(lock_o && unlock_o));

    // R8
    disable_clears_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!lock_o && !unlock_o && !status_o[3]));

    // R4
    lock_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_o) |-> $past(cmp_strobe));

    // R5
    unlock_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(unlock_o) |-> $past(cmp_strobe));

    // R9
    cfg_drops_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (win_sel != $past(win_sel) || cnt_sel != $past(cnt_sel)) |=> !lock_o);

    // R9
    cfg_keeps_unlock_chk: assert property (@(posedge clk) disable iff (rst)
        (enable && (win_sel != $past(win_sel) || cnt_sel != $past(cnt_sel)))
        |=> $stable(unlock_o));

    // R10
    status_mirror_chk: assert property (@(posedge clk) disable iff (rst)
        status_o[1:0] == {unlock_o, lock_o} && status_o[2] == enable);
endmodule

bind pll_lock_judge plj_checker u_plj_checker (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .win_sel    (win_sel),
    .cnt_sel    (cnt_sel),
    .cmp_strobe (cmp_strobe),
    .lock_o     (lock_o),
    .unlock_o   (unlock_o),
    .status_o   (status_o)
);

// File: tb/pll_lock_judge_test.sv
module pll_lock_judge_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic [1:0] win_sel = 2'd0;
    logic [1:0] cnt_sel = 2'd0;
    logic       phase_err = 1'b0;
    logic       cmp_strobe = 1'b0;
    logic       lock_o;
    logic       unlock_o;
    logic [3:0] status_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pll_lock_judge uut (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .win_sel    (win_sel),
        .cnt_sel    (cnt_sel),
        .phase_err  (phase_err),
        .cmp_strobe (cmp_strobe),
        .lock_o     (lock_o),
        .unlock_o   (unlock_o),
        .status_o   (status_o)
    );

    typedef struct packed {
        logic [7:0]  width;
        logic [11:0] reps;
        logic        exp_lock;
        logic        exp_unlock;
    } vec_t;

    // window 3 cycles, count 32
    localparam vec_t VEC [8] = '{
        '{8'd1, 12'd31, 1'b0, 1'b0},  // R4 not yet at 31
        '{8'd2, 12'd1,  1'b1, 1'b0},  // R4 R1 32nd good, width 2 < 3
        '{8'd3, 12'd1,  1'b0, 1'b1},  // R5 R1 width 3 out
        '{8'd0, 12'd1,  1'b0, 1'b0},  // R6 immediate clear
        '{8'd2, 12'd30, 1'b0, 1'b0},  // R4 restart after bad
        '{8'd5, 12'd1,  1'b0, 1'b1},  // R5
        '{8'd1, 12'd32, 1'b1, 1'b0},  // R4
        '{8'd1, 12'd5,  1'b1, 1'b0}   // R7 saturation
    };

    task automatic check(string req, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic one_cmp(int w);
        int period;
        period = w + 3;
        for (int i = 0; i < period; i++) begin
            @(negedge clk);
            phase_err  = (i < w);
            cmp_strobe = (i == period - 1);
        end
        @(negedge clk);
        phase_err  = 1'b0;
        cmp_strobe = 1'b0;
    endtask

    task automatic cmps(int w, int n);
        for (int k = 0; k < n; k++) one_cmp(w);
    endtask

    task automatic flags(string req, logic el, logic eu);
        check(req, {2'b00, unlock_o, lock_o}, {2'b00, eu, el});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R11 reset", status_o, 4'b0000);
        rst = 1'b0;
        @(negedge clk);
        check("R11 after reset", status_o, 4'b0000);
        enable = 1'b1;
        @(negedge clk);
        check("R10 enabled idle", status_o, 4'b0100);

        for (int v = 0; v < 8; v++) begin
            cmps(int'(VEC[v].width), int'(VEC[v].reps));
            flags($sformatf("R4/R5/R6/R7 vector %0d", v), VEC[v].exp_lock, VEC[v].exp_unlock);
        end
        check("R10 locked status", status_o, 4'b1101);

        // R9 count change drops lock, unlock stays low
        cnt_sel = 2'd1;
        @(negedge clk);
        flags("R9 cfg change while locked", 1'b0, 1'b0);
        check("R9 count restarted", {3'b000, status_o[3]}, 4'b0000);
        one_cmp(10);
        flags("R5 unlock set", 1'b0, 1'b1);
        check("R10 unlock status", status_o, 4'b0110);
        win_sel = 2'd3;
        @(negedge clk);
        flags("R9 unlock held over cfg change", 1'b0, 1'b1);

        // R2 window 90 boundary
        one_cmp(89);
        flags("R2 R6 width 89 inside 90", 1'b0, 1'b0);
        one_cmp(90);
        flags("R2 R1 width 90 outside 90", 1'b0, 1'b1);

        // R3 count 128
        cmps(1, 127);
        flags("R3 127 good no lock", 1'b0, 1'b0);
        one_cmp(1);
        flags("R3 R4 128th good locks", 1'b1, 1'b0);

        win_sel = 2'd2;
        @(negedge clk);
        flags("R9 window change drops lock", 1'b0, 1'b0);
        one_cmp(29);
        flags("R2 width 29 inside 30", 1'b0, 1'b0);
        one_cmp(30);
        flags("R2 width 30 outside 30", 1'b0, 1'b1);
        win_sel = 2'd1;
        @(negedge clk);
        one_cmp(9);
        flags("R2 width 9 inside 10", 1'b0, 1'b0);
        one_cmp(10);
        flags("R2 width 10 outside 10", 1'b0, 1'b1);

        // R8 disable
        enable = 1'b0;
        @(negedge clk);
        check("R8 disabled", status_o, 4'b0000);
        one_cmp(12);
        check("R8 strobe ignored while disabled", status_o, 4'b0000);
        enable = 1'b1;
        cnt_sel = 2'd0;
        @(negedge clk);
        cmps(1, 31);
        flags("R8 re-enable 31 good", 1'b0, 1'b0);
        one_cmp(1);
        flags("R8 re-enable 32 good", 1'b1, 1'b0);
        check("R10 final status", status_o, 4'b1101);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule